// File: doc/BRIEF.md
# Pipelined Down-Counting Interval Timer

This block is a down-counting interval timer clocked by a single system clock. It counts either every system clock cycle or the rising edges seen on an external count pin. Each count request first passes through a rising-edge detector when the external source is selected. It then travels through a fixed-length chain of registered stages, and only the last stage is allowed to decrement the counter. The count request therefore lands a known number of cycles after it was raised, and one external edge can never be counted twice.

When the counter sits at zero and a decrement arrives, the timer raises a one-cycle underflow pulse and reloads from its reload latch on the same edge. A force-load strobe also reloads the counter. Both events empty the request chain, so no request that was in flight before the reload can take a count off the new value. In one-shot mode the run bit clears on underflow and the counter rests at the reload value. In continuous mode counting carries on.

Top module: `ivl_timer`

## Requirements
- R1: After reset, count_out and the reload latch are 0xFFFF, running is 0 and underflow is 0.
- R2: With ctrl_src_ext = 0 (system clock source), the first decrement after the edge that starts the timer or reloads it happens 5 clock edges later. After that the counter drops by one on every edge.
- R3: With ctrl_src_ext = 1 (external source), a clock edge that samples cnt_in high, when the previous edge sampled it low, takes exactly one off the counter, 4 edges later.
- R4: While cnt_in stays high, the counter is decremented only once, for the rising edge. Two rising edges produce exactly two decrements.
- R5: An edge at which a decrement is due while the counter is 0 loads the counter from the reload latch. underflow is high for exactly the one cycle that follows that edge.
- R6: An underflow or a force load discards every request still in the chain. No decrement occurs until a new request has travelled the full chain.
- R7: With ctrl_oneshot = 1, underflow clears running, and the counter then holds the reload value with no extra tick.
- R8: With ctrl_oneshot = 0, running stays set on underflow and counting resumes from the reloaded value.
- R9: A control write with ctrl_force_load = 1 loads the counter from the reload latch at that edge, whatever the value of ctrl_start.
- R10: A control write with ctrl_start = 0 freezes count_out from that edge on. Requests still in flight are dropped.
- R11: A reload latch write alone leaves count_out unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reload_we | input | 1 | Write strobe for the reload latch |
| reload_data | input | 16 | New reload latch value |
| ctrl_we | input | 1 | Write strobe for the control bits below |
| ctrl_start | input | 1 | Run bit value to write |
| ctrl_oneshot | input | 1 | 1 = one-shot, 0 = continuous |
| ctrl_src_ext | input | 1 | 1 = count cnt_in rising edges, 0 = count clock cycles |
| ctrl_force_load | input | 1 | 1 = reload counter from latch at this write |
| cnt_in | input | 1 | External count input |
| underflow | output | 1 | One-cycle pulse after an underflow reload |
| running | output | 1 | Current run bit |
| count_out | output | 16 | Current counter value |

## Verification
A request stage that fails to clear shows up at the ports as a second decrement within four edges of a reload. A stage that fires twice shows up as a count lower than the number of external edges, about four edges after the edge that caused it. A wrong run bit shows up as a counter that moves after a stop, or one that sits still after an underflow in continuous mode. The vector table follows cnt_in edge by edge, so any early, late, missing or doubled decrement shows as a miscompare within one cycle of its expected edge.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;

    typedef enum logic {
        SRC_CLK = 1'b0,
        SRC_EXT = 1'b1
    } src_sel_e;

    typedef struct packed {
        logic     start;
        logic     oneshot;
        src_sel_e src;
    } tmr_ctrl_t;

    function automatic tmr_ctrl_t pack_ctrl(logic start, logic oneshot, logic ext);
        tmr_ctrl_t c;
        c.start   = start;
        c.oneshot = oneshot;
        c.src     = src_sel_e'(ext);
        return c;
    endfunction

endpackage

// File: rtl/ivl_edge_det.sv
module ivl_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);
    typedef struct packed {
        logic prev;
    } edge_regs_t;

    edge_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.prev = level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // high for exactly one cycle per low-to-high transition
    assign rise_o = level_i & ~r_q.prev;
endmodule

// File: rtl/ivl_req_pipe.sv
module ivl_req_pipe #(
    parameter int STAGES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic flush_i,
    output logic fire_o
);
    logic [STAGES-1:0] stg_d, stg_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb stg_d = flush_i ? 1'b0 : req_i;
        end else begin : g_chain
            always_comb stg_d = flush_i ? '0 : {stg_q[STAGES-2:0], req_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign fire_o = stg_q[STAGES-1];
endmodule

// File: rtl/ivl_down_ctr.sv
module ivl_down_ctr #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_val_i,
    input  logic             dec_i,
    output logic [WIDTH-1:0] count_o,
    output logic             zero_o
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)     cnt_d = load_val_i;
        else if (dec_i) cnt_d = cnt_q - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '1;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
    assign zero_o  = (cnt_q == '0);
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
    import ivl_timer_pkg::*;
#(
    parameter int WIDTH  = 16,
    parameter int STAGES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_we,
    input  logic [WIDTH-1:0] reload_data,
    input  logic             ctrl_we,
    input  logic             ctrl_start,
    input  logic             ctrl_oneshot,
    input  logic             ctrl_src_ext,
    input  logic             ctrl_force_load,
    input  logic             cnt_in,
    output logic             underflow,
    output logic             running,
    output logic [WIDTH-1:0] count_out
);
    typedef struct packed {
        logic [WIDTH-1:0] latch;
        tmr_ctrl_t        ctrl;
        logic             uf;
    } top_regs_t;

    top_regs_t r_d, r_q;

    logic             ext_rise;
    logic             fire;
    logic             cnt_zero;
    logic             req;
    logic             force_evt;
    logic             uf_evt;
    logic             dec;
    logic             load;
    logic             flush;
    logic [WIDTH-1:0] latch_q;
    logic             oneshot_q;

    ivl_edge_det u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (cnt_in),
        .rise_o  (ext_rise)
    );

    ivl_req_pipe #(.STAGES(STAGES)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .flush_i (flush),
        .fire_o  (fire)
    );

    ivl_down_ctr #(.WIDTH(WIDTH)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (r_q.latch),
        .dec_i      (dec),
        .count_o    (count_out),
        .zero_o     (cnt_zero)
    );

    // request source: every cycle or one pulse per external rising edge
    always_comb begin
        req       = r_q.ctrl.start & ((r_q.ctrl.src == SRC_EXT) ? ext_rise : 1'b1);
        force_evt = ctrl_we & ctrl_force_load;
        uf_evt    = fire & r_q.ctrl.start & cnt_zero;
        dec       = fire & r_q.ctrl.start & ~cnt_zero;
        load      = force_evt | uf_evt;
        // a reload or a stopped timer empties every stage
        flush     = load | ~r_q.ctrl.start;
    end

    always_comb begin
        r_d    = r_q;
        r_d.uf = uf_evt;
        if (reload_we) r_d.latch = reload_data;
        if (ctrl_we)
            r_d.ctrl = pack_ctrl(ctrl_start, ctrl_oneshot, ctrl_src_ext);
        else if (uf_evt && r_q.ctrl.oneshot)
            r_d.ctrl.start = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.latch <= '1;
            r_q.ctrl  <= pack_ctrl(1'b0, 1'b0, 1'b0);
            r_q.uf    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign latch_q   = r_q.latch;
    assign oneshot_q = r_q.ctrl.oneshot;
    assign underflow = r_q.uf;
    assign running   = r_q.ctrl.start;
endmodule

// File: rtl/ivl_timer_chk.sv
module ivl_timer_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_we,
    input logic             underflow,
    input logic             running,
    input logic [WIDTH-1:0] count_out,
    input logic [WIDTH-1:0] latch_q,
    input logic             oneshot_q
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // R2: the counter only steps down by one or takes the latch value
    a_r2_step_or_load: assert property (@(posedge clk) disable iff (!rst_n)
        (count_out != $past(count_out)) |->
            ((count_out == $past(count_out) - ONE) || (count_out == $past(latch_q))));

    // R5: underflow follows a counter that was zero
    a_r5_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> ($past(count_out) == '0));

    // R5: the pulse lasts a single cycle
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> !underflow);

    // R6: no decrement on the edge right after a reload
    a_r6_no_stray_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !ctrl_we) |=> $stable(count_out));

    // R7: one-shot underflow drops the run bit
    a_r7_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && $past(oneshot_q) && !$past(ctrl_we)) |-> !running);

    // R10: a stopped timer keeps its value unless control is written
    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !ctrl_we) |=> $stable(count_out));
endmodule

bind ivl_timer ivl_timer_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_we   (ctrl_we),
    .underflow (underflow),
    .running   (running),
    .count_out (count_out),
    .latch_q   (latch_q),
    .oneshot_q (oneshot_q)
);

// File: tb/ivl_timer_test.sv
module ivl_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 27;

    // {cnt_in, expected count_out, expected underflow}
    localparam logic [17:0] VECS [0:NVEC-1] = '{
        {1'b1, 16'd3, 1'b0}, {1'b1, 16'd3, 1'b0}, {1'b0, 16'd3, 1'b0},
        {1'b0, 16'd3, 1'b0}, {1'b0, 16'd2, 1'b0}, {1'b1, 16'd2, 1'b0},
        {1'b0, 16'd2, 1'b0}, {1'b1, 16'd2, 1'b0}, {1'b0, 16'd2, 1'b0},
        {1'b0, 16'd1, 1'b0}, {1'b0, 16'd1, 1'b0}, {1'b0, 16'd0, 1'b0},
        {1'b1, 16'd0, 1'b0}, {1'b0, 16'd0, 1'b0}, {1'b1, 16'd0, 1'b0},
        {1'b0, 16'd0, 1'b0}, {1'b0, 16'd3, 1'b1}, {1'b0, 16'd3, 1'b0},
        {1'b0, 16'd3, 1'b0}, {1'b0, 16'd3, 1'b0}, {1'b0, 16'd3, 1'b0},
        {1'b0, 16'd3, 1'b0}, {1'b1, 16'd3, 1'b0}, {1'b0, 16'd3, 1'b0},
        {1'b0, 16'd3, 1'b0}, {1'b0, 16'd3, 1'b0}, {1'b0, 16'd2, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reload_we = 1'b0;
    logic [15:0] reload_data = '0;
    logic        ctrl_we = 1'b0;
    logic        ctrl_start = 1'b0;
    logic        ctrl_oneshot = 1'b0;
    logic        ctrl_src_ext = 1'b0;
    logic        ctrl_force_load = 1'b0;
    logic        cnt_in = 1'b0;
    logic        underflow;
    logic        running;
    logic [15:0] count_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ivl_timer uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .reload_we       (reload_we),
        .reload_data     (reload_data),
        .ctrl_we         (ctrl_we),
        .ctrl_start      (ctrl_start),
        .ctrl_oneshot    (ctrl_oneshot),
        .ctrl_src_ext    (ctrl_src_ext),
        .ctrl_force_load (ctrl_force_load),
        .cnt_in          (cnt_in),
        .underflow       (underflow),
        .running         (running),
        .count_out       (count_out)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr_reload(input logic [15:0] v);
        reload_we   = 1'b1;
        reload_data = v;
        @(negedge clk);
        reload_we   = 1'b0;
    endtask

    task automatic wr_ctrl(input logic st, input logic os, input logic ext, input logic fl);
        ctrl_we         = 1'b1;
        ctrl_start      = st;
        ctrl_oneshot    = os;
        ctrl_src_ext    = ext;
        ctrl_force_load = fl;
        @(negedge clk);
        ctrl_we         = 1'b0;
        ctrl_force_load = 1'b0;
    endtask

    initial begin
        step(3);
        chk("R1 count", count_out, 16'hFFFF);
        chk("R1 running", {15'd0, running}, 16'd0);
        chk("R1 underflow", {15'd0, underflow}, 16'd0);
        rst_n = 1'b1;
        step(1);
        chk("R1 count after release", count_out, 16'hFFFF);

        // external edge source, continuous, reload 3
        wr_reload(16'd3);
        chk("R11 latch write keeps count", count_out, 16'hFFFF);
        wr_ctrl(1'b1, 1'b0, 1'b1, 1'b1);
        chk("R9 force load", count_out, 16'd3);
        for (int i = 0; i < NVEC; i++) begin
            cnt_in = VECS[i][17];
            @(negedge clk);
            chk($sformatf("R3/R4/R5/R6 vec%0d count", i), count_out, VECS[i][16:1]);
            chk($sformatf("R5 vec%0d underflow", i), {15'd0, underflow}, {15'd0, VECS[i][0]});
        end

        // one-shot, clock source, reload 2
        wr_reload(16'd2);
        wr_ctrl(1'b1, 1'b1, 1'b0, 1'b1);
        chk("R9 oneshot load", count_out, 16'd2);
        step(4);
        chk("R2 no dec before latency", count_out, 16'd2);
        step(1);
        chk("R2 first dec", count_out, 16'd1);
        step(1);
        chk("R2 second dec", count_out, 16'd0);
        step(1);
        chk("R7 reload on underflow", count_out, 16'd2);
        chk("R5 oneshot underflow pulse", {15'd0, underflow}, 16'd1);
        chk("R7 running cleared", {15'd0, running}, 16'd0);
        step(5);
        chk("R7 no extra tick", count_out, 16'd2);
        chk("R5 pulse ended", {15'd0, underflow}, 16'd0);

        // continuous, clock source, reload 1
        wr_reload(16'd1);
        wr_ctrl(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R9 cont load", count_out, 16'd1);
        step(5);
        chk("R2 cont first dec", count_out, 16'd0);
        step(1);
        chk("R8 reload", count_out, 16'd1);
        chk("R8 underflow", {15'd0, underflow}, 16'd1);
        chk("R8 still running", {15'd0, running}, 16'd1);
        step(4);
        chk("R6 flushed after underflow", count_out, 16'd1);
        step(1);
        chk("R8 resumed", count_out, 16'd0);
        step(1);
        chk("R8 second underflow", {15'd0, underflow}, 16'd1);

        // stop freezes the count
        wr_reload(16'd100);
        wr_ctrl(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R9 load 100", count_out, 16'd100);
        step(5);
        chk("R2 dec 99", count_out, 16'd99);
        step(4);
        chk("R2 steady dec 95", count_out, 16'd95);
        wr_ctrl(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R10 last dec at stop edge", count_out, 16'd94);
        chk("R10 running 0", {15'd0, running}, 16'd0);
        step(6);
        chk("R10 frozen", count_out, 16'd94);
        wr_reload(16'd7);
        chk("R11 latch write while stopped", count_out, 16'd94);
        wr_ctrl(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R9 force load while stopped", count_out, 16'd7);
        step(3);
        chk("R10 stays after load", count_out, 16'd7);

        // force load while the chain is full
        wr_ctrl(1'b1, 1'b0, 1'b0, 1'b1);
        step(5);
        chk("R2 dec 6", count_out, 16'd6);
        step(1);
        chk("R2 dec 5", count_out, 16'd5);
        wr_ctrl(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R9 force mid-run", count_out, 16'd7);
        step(4);
        chk("R6 flushed after force", count_out, 16'd7);
        step(1);
        chk("R6 resume after force", count_out, 16'd6);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule